// File: doc/BRIEF.md
# Interprocessor Send and Mailbox Dispatcher

This block sits between the cores of a multi-core cluster and their per-core interrupt and mailbox banks. A requesting core hands it one command at a time over a valid/ready handshake. A short vector-send command names a target core and a vector number. The block answers with a one-cycle strobe toward the bank of that core, which sets the named pending bit. A long mail-send or any-send command carries a 32-bit payload in its upper half. For these the block writes the payload into a target core's mailbox word, or into any 16-bit register address of that core. The write goes over a simple 32-bit request/acknowledge master port.

Bits 30:27 of a long command form a byte mask, and a set bit marks a byte to **keep**. When any mask bit is set, the block reads the target word, merges it and writes it back. When none is set, it writes the payload directly with no read. Every accepted command ends with a one-cycle done pulse that carries an ok or decode-error status. A command that is rejected causes no bus access and no strobe.

Back-pressure rules: `cmd_ready` is high only while the block is idle. A command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. The requester must hold the command fields stable until that cycle. On the master side `mst_req` and its address, direction and data stay stable until `mst_ack` is seen high, and the target may stall for any number of cycles.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset `cmd_ready` is 1 and `mst_req`, `done_pulse` and `sig_valid` are 0. `cmd_ready` drops in the cycle after a command is accepted and rises again only in the cycle after that command's done pulse.
- R2: The target core is `cmd_data[25:16]`. If this value is at or above `NUM_CORES`, the command completes with `done_err`=1 in the cycle after acceptance, with no master access and no `sig_valid`.
- R3: `cmd_op`=0 with `cmd_wide`=0 is a vector send. In the cycle after acceptance, `sig_valid` is high for exactly one cycle with `sig_core` = target and `sig_vec` = `cmd_data[4:0]`, together with `done_pulse` and `done_err`=0.
- R4: `cmd_op`=1 is a mail send. Its access address is `MBX_BASE` + 0x20 + (`cmd_data` AND 0x1C), so bits 1:0 and bits above 4 of the low half have no effect on the address.
- R5: `cmd_op`=2 is an any send. Its access address is `cmd_data[15:0]`. For both long commands `mst_core` carries the target core.
- R6: For a long command with a nonzero keep mask `cmd_data[30:27]`, the block issues one read and then one write to the same address. In the written word, byte i comes from the read data where mask bit i is 1 and from `cmd_data[32+8i+7:32+8i]` where it is 0.
- R7: For a long command with keep mask 0, no read is issued, and a single write of `cmd_data[63:32]` is made.
- R8: A long op with `cmd_wide`=0, a vector send with `cmd_wide`=1, and `cmd_op`=3 are all rejected with `done_err`=1, with no master access and no strobe.
- R9: `mst_req` with its `mst_we`, `mst_addr` and `mst_wdata` stays stable until `mst_ack`. The done pulse with `done_err`=0 follows the acknowledged write, and each accepted command yields exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 0 vector send, 1 mail send, 2 any send, 3 reserved |
| cmd_wide | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| cmd_data | input | 64 | Command value |
| done_pulse | output | 1 | One-cycle completion |
| done_err | output | 1 | Decode error flag, valid with done_pulse |
| sig_valid | output | 1 | One-cycle vector set strobe |
| sig_core | output | CORE_W | Core whose pending bit is set |
| sig_vec | output | 5 | Vector number to set |
| mst_req | output | 1 | Master access request |
| mst_we | output | 1 | 1 write, 0 read |
| mst_core | output | CORE_W | Core whose register space is accessed |
| mst_addr | output | ADDR_W | Register address |
| mst_wdata | output | 32 | Write data |
| mst_ack | input | 1 | Access done; read data valid this cycle |
| mst_rdata | input | 32 | Read data |

## Verification
The bench goes after the inverted sense of the byte mask. Mixed masks such as 0101 and 1000, and the all-keep mask 1111, are used. A design that treats mask bits as write enables would return the old bytes where fresh payload belongs. The all-zero mask must produce a lone write; a design that always reads first shows an unexpected read on the master port. Target IDs of exactly `NUM_CORES` and of 1023, wrong access widths and the reserved op must finish as errors with a silent master port. A design that let any of them through would show a stray access or strobe. The bench also varies the acknowledge latency and checks mailbox addresses carrying junk low bits. A design that let a request move before its acknowledge, or that used the unmasked low bits, would produce accesses that do not match the expected ones.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    OP_VEC  = 2'd0,
    OP_MAIL = 2'd1,
    OP_ANY  = 2'd2,
    OP_RSVD = 2'd3
  } ipi_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } ipi_st_e;

  localparam int CMD_W    = 64;
  localparam int WORD_W   = 32;
  localparam int BYTES    = WORD_W / 8;
  localparam int ID_LSB   = 16;
  localparam int ID_W     = 10;
  localparam int VEC_W    = 5;
  localparam int MASK_LSB = 27;
  localparam int MBX_OFS  = 'h20;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int ADDR_W    = 16,
  parameter int MBX_BASE  = 'h1000
) (
  input  ipi_op_e              op,
  input  logic                 wide,
  input  logic [CMD_W-1:0]     data,
  output logic                 ok,
  output logic [CORE_W-1:0]    core,
  output logic [VEC_W-1:0]     vec,
  output logic [ADDR_W-1:0]    addr,
  output logic [BYTES-1:0]     keep,
  output logic [WORD_W-1:0]    upper
);
  logic [ID_W-1:0] tgt_id;
  logic            in_range;
  logic            shape_ok;
  logic            unused_bits;

  assign tgt_id   = data[ID_LSB +: ID_W];
  assign in_range = (int'(tgt_id) < NUM_CORES);
  assign core     = tgt_id[CORE_W-1:0];
  assign vec      = data[VEC_W-1:0];
  assign keep     = data[MASK_LSB +: BYTES];
  assign upper    = data[CMD_W-1 -: WORD_W];
  assign unused_bits = ^{data[31], data[26]};

  always_comb begin
    unique case (op)
      OP_VEC:          shape_ok = !wide;
      OP_MAIL, OP_ANY: shape_ok = wide;
      default:         shape_ok = 1'b0;
    endcase
  end

  assign ok = in_range && shape_ok;

  always_comb begin
    unique case (op)
      OP_MAIL: addr = ADDR_W'(MBX_BASE) + ADDR_W'(MBX_OFS)
                      + ADDR_W'({data[4:2], 2'b00});
      OP_ANY:  addr = data[ADDR_W-1:0];
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge #(
  parameter int BYTES = 4
) (
  input  logic [BYTES-1:0]   keep,
  input  logic [8*BYTES-1:0] old_word,
  input  logic [8*BYTES-1:0] new_word,
  output logic [8*BYTES-1:0] merged
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign merged[8*b +: 8] = keep[b] ? old_word[8*b +: 8] : new_word[8*b +: 8];
  end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 16,
  parameter int MBX_BASE  = 'h1000,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_wide,
  input  logic [63:0]        cmd_data,
  output logic               done_pulse,
  output logic               done_err,
  output logic               sig_valid,
  output logic [CORE_W-1:0]  sig_core,
  output logic [4:0]         sig_vec,
  output logic               mst_req,
  output logic               mst_we,
  output logic [CORE_W-1:0]  mst_core,
  output logic [ADDR_W-1:0]  mst_addr,
  output logic [31:0]        mst_wdata,
  input  logic               mst_ack,
  input  logic [31:0]        mst_rdata
);
  ipi_st_e             state;
  ipi_op_e             op_in;
  logic                dec_ok;
  logic [CORE_W-1:0]   dec_core;
  logic [VEC_W-1:0]    dec_vec;
  logic [ADDR_W-1:0]   dec_addr;
  logic [BYTES-1:0]    dec_keep;
  logic [WORD_W-1:0]   dec_upper;
  logic [WORD_W-1:0]   merged;

  logic                r_is_vec;
  logic                r_err;
  logic [CORE_W-1:0]   r_core;
  logic [VEC_W-1:0]    r_vec;
  logic [ADDR_W-1:0]   r_addr;
  logic [BYTES-1:0]    r_keep;
  logic [WORD_W-1:0]   r_word;

  assign op_in = ipi_op_e'(cmd_op);

  ipi_cmd_decode #(
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W),
    .ADDR_W    (ADDR_W),
    .MBX_BASE  (MBX_BASE)
  ) u_dec (
    .op    (op_in),
    .wide  (cmd_wide),
    .data  (cmd_data),
    .ok    (dec_ok),
    .core  (dec_core),
    .vec   (dec_vec),
    .addr  (dec_addr),
    .keep  (dec_keep),
    .upper (dec_upper)
  );

  ipi_byte_merge #(.BYTES(BYTES)) u_merge (
    .keep     (r_keep),
    .old_word (mst_rdata),
    .new_word (r_word),
    .merged   (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      r_is_vec <= 1'b0;
      r_err    <= 1'b0;
      r_core   <= '0;
      r_vec    <= '0;
      r_addr   <= '0;
      r_keep   <= '0;
      r_word   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          r_is_vec <= (op_in == OP_VEC);
          r_err    <= !dec_ok;
          r_core   <= dec_core;
          r_vec    <= dec_vec;
          r_addr   <= dec_addr;
          r_keep   <= dec_keep;
          r_word   <= dec_upper;
          if (!dec_ok || op_in == OP_VEC) state <= ST_DONE;
          else if (dec_keep != '0)        state <= ST_READ;
          else                            state <= ST_WRITE;
        end
        ST_READ: if (mst_ack) begin
          r_word <= merged;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (mst_ack) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state == ST_IDLE);
  assign mst_req    = (state == ST_READ) || (state == ST_WRITE);
  assign mst_we     = (state == ST_WRITE);
  assign mst_core   = r_core;
  assign mst_addr   = r_addr;
  assign mst_wdata  = r_word;
  assign done_pulse = (state == ST_DONE);
  assign done_err   = (state == ST_DONE) && r_err;
  assign sig_valid  = (state == ST_DONE) && r_is_vec && !r_err;
  assign sig_core   = r_core;
  assign sig_vec    = r_vec;

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_err_without_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && done_err) |-> $past(cmd_valid && cmd_ready));

  assert_strobe_with_ok_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid |-> (done_pulse && !done_err));

  assert_read_then_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && !mst_we && mst_ack) |=> (mst_req && mst_we && $stable(mst_addr)));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && !mst_ack) |=> (mst_req && $stable(mst_we) && $stable(mst_addr)
                               && $stable(mst_wdata) && $stable(mst_core)));

  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && mst_we && mst_ack) |=> (done_pulse && !done_err));
endmodule

// File: tb/ipi_dispatch_tb_top.sv
`timescale 1ns/1ps
module ipi_dispatch_tb_top;
  localparam int NC   = 4;
  localparam int MBX  = 'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_wide = 1'b0;
  logic [63:0] cmd_data = '0;
  logic        done_pulse, done_err, sig_valid;
  logic [1:0]  sig_core;
  logic [4:0]  sig_vec;
  logic        mst_req, mst_we;
  logic [1:0]  mst_core;
  logic [15:0] mst_addr;
  logic [31:0] mst_wdata;
  logic        mst_ack = 1'b0;
  logic [31:0] mst_rdata = '0;

  ipi_dispatch #(.NUM_CORES(NC), .ADDR_W(16), .MBX_BASE(MBX)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wide(cmd_wide), .cmd_data(cmd_data),
    .done_pulse(done_pulse), .done_err(done_err), .sig_valid(sig_valid),
    .sig_core(sig_core), .sig_vec(sig_vec), .mst_req(mst_req), .mst_we(mst_we),
    .mst_core(mst_core), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .mst_ack(mst_ack), .mst_rdata(mst_rdata)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lat = 0;
  int wait_cnt = 0;
  int dones = 0;
  bit busy = 1'b0;

  logic [31:0] mem [int];
  logic [50:0] exp_bus [$];
  string       bus_tag [$];
  logic [6:0]  exp_sig [$];
  logic        exp_done [$];
  string       done_tag [$];

  function automatic logic [31:0] rd_model(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // memory-side responder with programmable acknowledge latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mst_req && mst_ack) begin
      if (mst_we) mem[int'(mst_addr)] = mst_wdata;
      mst_ack  <= 1'b0;
      wait_cnt <= 0;
    end else if (mst_req) begin
      if (wait_cnt >= lat) begin
        mst_ack   <= 1'b1;
        mst_rdata <= rd_model(mst_addr);
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      finish_run();
    end
  end

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cmd_ready == !busy, "R1 ready", {63'd0, cmd_ready}, {63'd0, !busy});
      if (mst_req && mst_ack) begin
        logic [50:0] act;
        act = {mst_we, mst_core, mst_addr, mst_we ? mst_wdata : 32'h0};
        if (exp_bus.size() == 0) chk(1'b0, "R8 unexpected access", {13'd0, act}, 64'd0);
        else begin
          logic [50:0] e;
          string t;
          e = exp_bus.pop_front();
          t = bus_tag.pop_front();
          chk(act == e, t, {13'd0, act}, {13'd0, e});
        end
      end
      if (sig_valid) begin
        if (exp_sig.size() == 0) chk(1'b0, "R2 unexpected strobe", {57'd0, sig_core, sig_vec}, 64'd0);
        else begin
          logic [6:0] e;
          e = exp_sig.pop_front();
          chk({sig_core, sig_vec} == e, "R3 strobe", {57'd0, sig_core, sig_vec}, {57'd0, e});
        end
      end
      if (done_pulse) begin
        if (exp_done.size() == 0) chk(1'b0, "R9 extra done", 64'd1, 64'd0);
        else begin
          logic e;
          string t;
          e = exp_done.pop_front();
          t = done_tag.pop_front();
          chk(done_err == e, t, {63'd0, done_err}, {63'd0, e});
        end
        busy = 1'b0;
        dones++;
      end
      if (cmd_valid && cmd_ready) busy = 1'b1;
    end
  end

  function automatic logic [63:0] mk(input logic [31:0] hi, input logic [3:0] keep,
                                     input logic [9:0] id, input logic [15:0] lo);
    return {hi, 1'b1, keep, 1'b1, id, lo};
  endfunction

  task automatic send(input logic [1:0] op, input bit wide, input logic [63:0] d, input string tag);
    logic [9:0]  id;
    logic [3:0]  keep;
    logic [15:0] a;
    logic [31:0] w;
    int d0;
    bit good;
    id   = d[25:16];
    keep = d[30:27];
    good = (int'(id) < NC) && ((op == 2'd0 && !wide) || ((op == 2'd1 || op == 2'd2) && wide));
    if (!good) begin
      exp_done.push_back(1'b1);
      done_tag.push_back({tag, " error done"});
    end else if (op == 2'd0) begin
      exp_sig.push_back({id[1:0], d[4:0]});
      exp_done.push_back(1'b0);
      done_tag.push_back({tag, " done"});
    end else begin
      if (op == 2'd1) a = 16'(MBX + 'h20 + int'(d[4:2]) * 4);
      else a = d[15:0];
      w = d[63:32];
      if (keep != 4'd0) begin
        logic [31:0] old;
        old = rd_model(a);
        for (int i = 0; i < 4; i++) if (keep[i]) w[8*i +: 8] = old[8*i +: 8];
        exp_bus.push_back({1'b0, id[1:0], a, 32'h0});
        bus_tag.push_back({tag, " R6 read"});
      end
      exp_bus.push_back({1'b1, id[1:0], a, w});
      bus_tag.push_back({tag, " write"});
      exp_done.push_back(1'b0);
      done_tag.push_back({tag, " done"});
    end
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = op; cmd_wide = wide; cmd_data = d;
    do @(negedge clk); while (!cmd_ready);
    d0 = dones;
    @(posedge clk); #2;
    cmd_valid = 1'b0; cmd_data = ~d;
    while (dones == d0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(cmd_ready == 1'b1 && mst_req == 1'b0 && done_pulse == 1'b0 && sig_valid == 1'b0,
        "R1 reset state", {60'd0, cmd_ready, mst_req, done_pulse, sig_valid}, 64'h8);
    rst_n = 1'b1;
    // R3 vector sends
    send(2'd0, 1'b0, mk(32'hFFFF_FFFF, 4'hF, 10'd0, 16'hFFE0), "R3 vec0 core0");
    send(2'd0, 1'b0, mk(32'h0, 4'h0, 10'd3, 16'h001F), "R3 vec31 core3");
    // R2 bad targets
    send(2'd0, 1'b0, mk(32'h0, 4'h0, 10'd4, 16'h0005), "R2 id=NUM_CORES");
    send(2'd1, 1'b1, mk(32'h1234_5678, 4'h0, 10'd1023, 16'h0004), "R2 id=1023 mail");
    // R8 shape errors
    send(2'd0, 1'b1, mk(32'h0, 4'h0, 10'd1, 16'h0003), "R8 wide vector");
    send(2'd1, 1'b0, mk(32'hAAAA_5555, 4'h0, 10'd2, 16'h0008), "R8 narrow mail");
    send(2'd2, 1'b0, mk(32'hAAAA_5555, 4'h3, 10'd2, 16'h0100), "R8 narrow any");
    send(2'd3, 1'b1, mk(32'hAAAA_5555, 4'h0, 10'd0, 16'h0100), "R8 reserved op");
    // R4 R7 mailbox slot with junk low bits, no read
    send(2'd1, 1'b1, mk(32'hCAFE_F00D, 4'h0, 10'd2, 16'hFFFF), "R4 R7 mail slot7");
    send(2'd1, 1'b1, mk(32'h0102_0304, 4'h0, 10'd1, 16'h0020), "R4 R7 mail slot0");
    // R6 merges
    send(2'd1, 1'b1, mk(32'hA1B2_C3D4, 4'b0101, 10'd3, 16'h0008), "R6 mail keep0101");
    send(2'd1, 1'b1, mk(32'h1111_2222, 4'b1111, 10'd0, 16'h0014), "R6 mail keepall");
    // R5 any send, varied latency for R9
    lat = 3;
    send(2'd2, 1'b1, mk(32'h7777_8888, 4'h0, 10'd1, 16'h0ABC), "R5 R7 any");
    send(2'd2, 1'b1, mk(32'h9ABC_DEF0, 4'b1000, 10'd2, 16'hFFFE), "R5 R6 any keep1000");
    lat = 1;
    send(2'd2, 1'b1, mk(32'h5555_AAAA, 4'b0110, 10'd3, 16'h0ABC), "R6 R9 any reread");
    send(2'd0, 1'b0, mk(32'h0, 4'h0, 10'd2, 16'h0011), "R3 R9 vec after bus");
    repeat (4) @(negedge clk);
    chk(exp_bus.size() == 0 && exp_sig.size() == 0 && exp_done.size() == 0, "R9 all events seen",
        64'(exp_bus.size() + exp_sig.size() + exp_done.size()), 64'd0);
    finish_run();
  end
endmodule